// File: doc/BRIEF.md
# Counted Clock Pulse Burst Generator

This block drives a clock-like output pin with an exact number of pulses on request and then reports completion. Software writes a pulse count into a count register on a 32-bit register bus; that write alone launches the burst. Each pulse lasts one divided period, high for the first half and low for the second. The divide ratio comes from a 2-bit input field and is captured when the burst starts.

When the low half of the final pulse ends, a sticky done flag in the status register is set. In the same cycle, a one-cycle strobe output is raised for the sequencer that waits on the burst. Software clears the flag by writing one to it. A typical use is a short burst of four pulses issued after a configuration data stream has ended.

Top module: `pulse_burst_gen`

## Requirements
- R1: A bus write of N (N > 0) to the count register (offset 0x8, count in the low 16 data bits) while idle starts a burst: `pulse_out` is high in the first cycle after the write edge, and exactly N pulses are produced.
- R2: Each pulse is high for D cycles and then low for D cycles, where D = 1, 2, 4, 8 for `ratio_sel` codes 0, 1, 2, 3. The code is sampled at the count write, and later changes do not affect the running burst.
- R3: `pulse_out` is low whenever no burst is running, including after reset.
- R4: Bit 0 of the status register (offset 0xC) reads 1 from the cycle a burst finishes and 0 while a burst runs. A count write that starts a burst clears it.
- R5: A status write with data bit 0 set clears the done flag. A status write with bit 0 clear leaves it unchanged.
- R6: `done_strobe` is high for exactly one cycle, the first cycle in which the status flag reads 1. For an N-pulse burst this is 2·N·D cycles after the write edge.
- R7: A count write that arrives while a burst runs is ignored. The pulse total, the timing and the remaining count are unchanged.
- R8: A count write of 0 while idle sets the done flag and raises `done_strobe` in the next cycle, and produces no pulse.
- R9: Reading the count register returns the number of pulses not yet completed. The value drops by one at the end of each pulse's low half.
- R10: After reset, the status reads 0, the count reads 0, and `done_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ratio_sel | input | 2 | Divide-ratio code: 0..3 gives divide-by 1, 2, 4, 8 |
| pulse_out | output | 1 | Pulse output, low when idle |
| done_strobe | output | 1 | One-cycle burst-complete strobe |

## Verification
The bench uses the default parameters: a 16-bit count, a 2-bit ratio code and a 4-bit address. The longest burst therefore has eight-cycle half-periods, and the full high/low shape of every ratio code can be compared cycle by cycle. Bursts of 1 to 4 pulses across all four codes, with the code flipped mid-burst, exercise the capture-at-start rule. A count write issued during a burst, a zero count, and both values of the clear bit cover the remaining branches.

// File: rtl/pb_pkg.sv
// Package: shared constants and helpers for the pulse burst generator.
// Assumes byte offsets fit in the bus address width used by the top.
package pb_pkg;
    localparam logic [7:0] OFS_COUNT  = 8'h08;
    localparam logic [7:0] OFS_STATUS = 8'h0C;

    // Width of a half-period counter able to hold the largest (D-1).
    function automatic int half_w(input int ratio_w);
        return (1 << ratio_w) - 1;
    endfunction
endpackage

// File: rtl/pb_regif.sv
// Register decode: turns bus writes into start/clear requests and
// multiplexes read data. Assumes writes are single-cycle qualified by wr.
module pb_regif #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  remaining,
    input  logic              done,
    output logic              wr_count,
    output logic              wr_clear,
    output logic [CNT_W-1:0]  count_val,
    output logic [DATA_W-1:0] rdata
);
    import pb_pkg::*;

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    // Write decode for the two registers.
    always_comb begin
        wr_count  = wr && (addr == A_COUNT);
        wr_clear  = wr && (addr == A_STATUS) && wdata[0];
        count_val = wdata[CNT_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == A_COUNT)
            rdata = DATA_W'(remaining);
        else if (addr == A_STATUS)
            rdata = DATA_W'(done);
    end
endmodule

// File: rtl/pb_pacer.sv
// Pacer: produces the high/low halves of each pulse at the captured
// divide ratio and flags the end of each pulse period.
// Assumes 'run' stays high from start until the last period ends.
module pb_pacer #(
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic               last,
    input  logic [RATIO_W-1:0] ratio,
    output logic               level,
    output logic               period_end
);
    localparam int HW = pb_pkg::half_w(RATIO_W);

    logic [RATIO_W-1:0] ratio_q;
    logic [HW-1:0]      phase;

    // Reload value for a half period of the given ratio code.
    function automatic logic [HW-1:0] half_len(input logic [RATIO_W-1:0] r);
        return HW'((1 << r) - 1);
    endfunction

    // End of a full period: low half with its counter at zero.
    always_comb period_end = run && !level && (phase == '0);

    // Half-period counter and output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level   <= 1'b0;
            phase   <= '0;
            ratio_q <= '0;
        end else if (start) begin
            level   <= 1'b1;
            phase   <= half_len(ratio);
            ratio_q <= ratio;
        end else if (run) begin
            if (phase != '0) begin
                phase <= phase - 1'b1;
            end else if (level) begin
                level <= 1'b0;
                phase <= half_len(ratio_q);
            end else if (!last) begin
                level <= 1'b1;
                phase <= half_len(ratio_q);
            end
        end
    end
endmodule

// File: rtl/pb_counter.sv
// Burst counter: tracks remaining pulses, the active state, the sticky
// done flag and the completion strobe. Assumes period_end only while active.
module pb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] count_val,
    input  logic             wr_clear,
    input  logic             period_end,
    output logic             start,
    output logic             active,
    output logic             last,
    output logic [CNT_W-1:0] remaining,
    output logic             done,
    output logic             strobe
);
    logic finish;

    // Start and finish conditions.
    always_comb begin
        start  = wr_count && !active && (count_val != '0);
        last   = (remaining == CNT_W'(1));
        finish = (wr_count && !active && (count_val == '0)) ||
                 (period_end && last);
    end

    // Remaining count and active state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            remaining <= '0;
        end else if (start) begin
            active    <= 1'b1;
            remaining <= count_val;
        end else if (period_end) begin
            remaining <= remaining - 1'b1;
            if (last)
                active <= 1'b0;
        end
    end

    // Sticky done flag (set wins over clear) and one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= finish;
            if (finish)
                done <= 1'b1;
            else if (start || wr_clear)
                done <= 1'b0;
        end
    end
endmodule

// File: rtl/pulse_burst_gen.sv
// Top: register-programmed counted pulse burst generator. A count write
// launches the burst; completion sets a write-one-to-clear flag and strobe.
// Assumes one bus write per cycle at most.
module pulse_burst_gen #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 16,
    parameter int RATIO_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [RATIO_W-1:0] ratio_sel,
    output logic               pulse_out,
    output logic               done_strobe
);
    logic             wr_count, wr_clear, start, active, last, period_end, done;
    logic [CNT_W-1:0] count_val, remaining;

    pb_regif #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .remaining(remaining), .done(done),
        .wr_count(wr_count), .wr_clear(wr_clear),
        .count_val(count_val), .rdata(bus_rdata)
    );

    pb_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .wr_count(wr_count), .count_val(count_val), .wr_clear(wr_clear),
        .period_end(period_end),
        .start(start), .active(active), .last(last),
        .remaining(remaining), .done(done), .strobe(done_strobe)
    );

    pb_pacer #(.RATIO_W(RATIO_W)) u_pacer (
        .clk(clk), .rst_n(rst_n),
        .start(start), .run(active), .last(last), .ratio(ratio_sel),
        .level(pulse_out), .period_end(period_end)
    );
endmodule

// File: rtl/pb_checker.sv
// Checker: temporal properties of the burst generator, bound to the top.
module pb_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pulse_out,
    input logic             done_strobe,
    input logic             done,
    input logic             active,
    input logic             wr_count,
    input logic             period_end,
    input logic [CNT_W-1:0] remaining
);
    // R3
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !pulse_out);

    // R1
    start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> pulse_out);

    // R6
    strobe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_strobe |-> done);

    // R6
    flag_rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> done_strobe);

    // R7
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && wr_count && !period_end) |=> (remaining == $past(remaining)));
endmodule

bind pulse_burst_gen pb_checker #(.CNT_W(CNT_W)) u_pb_checker (
    .clk(clk), .rst_n(rst_n), .pulse_out(pulse_out),
    .done_strobe(done_strobe), .done(done), .active(active),
    .wr_count(wr_count), .period_end(period_end), .remaining(remaining)
);

// File: tb/test_pulse_burst_gen.sv
module test_pulse_burst_gen;
    localparam logic [3:0] A_CNT = 4'h8;
    localparam logic [3:0] A_STA = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ratio_sel = 2'd0;
    logic        pulse_out, done_strobe;

    int vectors = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pulse_burst_gen i_pulse_burst_gen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ratio_sel(ratio_sel),
        .pulse_out(pulse_out), .done_strobe(done_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // One-cycle bus write; returns at the negedge after the write edge.
    task automatic bus_write(input logic [3:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        check(pulse_out == 1'b0, "R3", pulse_out, 0);
        check(done_strobe == 1'b0, "R10", done_strobe, 0);
        peek(A_STA, v); check(v == 0, "R10", v, 0);
        peek(A_CNT, v); check(v == 0, "R10", v, 0);
    endtask

    // R1 R2 R4 R6 R9: full cycle-by-cycle burst shape.
    task automatic t_burst(input int n, input int code);
        int d, v, errs;
        d = 1 << code;
        errs = 0;
        ratio_sel = 2'(code);
        bus_write(A_CNT, n);
        ratio_sel = ~2'(code);
        for (int k = 0; k < 2 * n * d; k++) begin
            if (pulse_out != ((k % (2 * d)) < d)) begin
                errs++;
                check(1'b0, "R2", pulse_out, int'((k % (2 * d)) < d));
            end
            peek(A_CNT, v);
            if (v != n - k / (2 * d)) begin
                errs++;
                check(1'b0, "R9", v, n - k / (2 * d));
            end
            if (k == 0) begin
                check(pulse_out == 1'b1, "R1", pulse_out, 1);
                peek(A_STA, v); check(v == 0, "R4", v, 0);
            end
            if (done_strobe) begin
                errs++;
                check(1'b0, "R6", 1, 0);
            end
            @(negedge clk);
        end
        check(errs == 0, "R2", errs, 0);
        check(done_strobe == 1'b1, "R6", done_strobe, 1);
        check(pulse_out == 1'b0, "R3", pulse_out, 0);
        peek(A_STA, v); check(v == 1, "R4", v, 1);
        peek(A_CNT, v); check(v == 0, "R9", v, 0);
        @(negedge clk);
        check(done_strobe == 1'b0, "R6", done_strobe, 0);
        check(pulse_out == 1'b0, "R3", pulse_out, 0);
    endtask

    // R7: a second count write during a burst changes nothing.
    task automatic t_busy_write();
        int v, rises, cyc;
        logic prev;
        ratio_sel = 2'd0;
        bus_write(A_CNT, 2);
        rises = 1; prev = pulse_out;
        bus_wr = 1'b1; bus_addr = A_CNT; bus_wdata = 9;
        @(negedge clk);
        bus_wr = 1'b0;
        peek(A_CNT, v); check(v == 2, "R7", v, 2);
        cyc = 1;
        while (!done_strobe && cyc < 100) begin
            if (pulse_out && !prev) rises++;
            prev = pulse_out;
            @(negedge clk);
            cyc++;
        end
        check(cyc == 4, "R7", cyc, 4);
        check(rises == 2, "R7", rises, 2);
        peek(A_CNT, v); check(v == 0, "R7", v, 0);
    endtask

    // R8: zero count completes at once without pulses.
    task automatic t_zero();
        int v;
        bus_write(A_STA, 1);
        bus_write(A_CNT, 0);
        check(done_strobe == 1'b1, "R8", done_strobe, 1);
        check(pulse_out == 1'b0, "R8", pulse_out, 0);
        peek(A_STA, v); check(v == 1, "R8", v, 1);
        @(negedge clk);
        check(done_strobe == 1'b0, "R8", done_strobe, 0);
        check(pulse_out == 1'b0, "R8", pulse_out, 0);
    endtask

    // R5: write-one-to-clear on the status flag.
    task automatic t_clear();
        int v;
        bus_write(A_STA, 0);
        peek(A_STA, v); check(v == 1, "R5", v, 1);
        bus_write(A_STA, 1);
        peek(A_STA, v); check(v == 0, "R5", v, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_burst(4, 0);
                t_burst(3, 1);
                t_burst(2, 3);
                t_burst(1, 2);
                t_busy_write();
                t_zero();
                t_clear();
            end
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule